// File: doc/BRIEF.md
# Preemptive Four-Level Link Output Channel

This block drives one physical link out of a wormhole router. Traffic reaches the link on four service levels. Each level has its own flit queue and its own credit count for the matching receive buffer on the far side of the link. In every cycle, a fixed-priority scheduler picks one level to send a single flit. Level 0 has the highest priority. A more urgent level can take the link in the middle of a packet on a less urgent level. The interrupted packet stays in its own queue and continues once the more urgent traffic has finished.

Each flit leaves with a two-bit level tag and with head and tail markers. These let the receiver sort interleaved packets back into its per-level buffers. Short control messages, such as requests, invalidations and acknowledgements, are meant to use the urgent levels. Long data responses use the less urgent levels. Flits enter through one push port per level, and credits return as one pulse per level.

Top module: `slr_port`

## Requirements
- R1: After reset the link is idle, every queue reports room, and every level holds CRED_DEPTH credits (default 4). Exactly that many flits of one level leave before any credit comes back.
- R2: When several levels are eligible in the same cycle, the lowest-numbered level sends. With one flit queued on each level at once, the link carries levels 0, 1, 2 and 3 in that order.
- R3: A more urgent level takes the link between two flits of a less urgent packet. The interrupted packet continues with its next flit as soon as no more urgent level is eligible.
- R4: A level is eligible only while its queue is non-empty and its credit count is above zero. A level with flits but no credit sends nothing.
- R5: Each flit sent uses one credit of its level, and each pulse on credit_i[l] adds one credit. If a send and a return on the same level fall in the same cycle, the count is unchanged.
- R6: Within a level, flits leave in the order they were pushed. None is lost or duplicated, whatever the interleaving with other levels.
- R7: At most one flit leaves per cycle. link_valid_o is low in every cycle in which no level is eligible.
- R8: A sent flit carries its level as an unsigned 2-bit value on link_sl_o. Its data and its head and tail bits are the values pushed with it.
- R9: in_ready_o[l] is low exactly while the queue of level l holds BUF_DEPTH flits (default 4). A push to a full queue is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 4 | Push strobe, one bit per level |
| in_data_i | input | 4*DATA_W | Flit payloads; level l uses bits [l*DATA_W +: DATA_W] |
| in_head_i | input | 4 | Head marker per level |
| in_tail_i | input | 4 | Tail marker per level |
| in_ready_o | output | 4 | Queue of the level has room |
| credit_i | input | 4 | Credit return pulse per level |
| link_valid_o | output | 1 | A flit is on the link this cycle |
| link_data_o | output | DATA_W | Flit payload |
| link_sl_o | output | 2 | Level tag of the flit |
| link_head_o | output | 1 | Flit opens a packet |
| link_tail_o | output | 1 | Flit closes a packet |

## Verification
Two functions can fall in the same cycle. The first is a credit return on the level that is sending a flit. The second is a push into the queue that is being drained. The stimulus returns credits on every level that has some outstanding. It also keeps several levels pushing while they send, so both collisions happen often, together with preemption mid-packet. A bench model of the queues and credits predicts which level goes out, and which flit, in every cycle. It also predicts each ready bit, so a lost credit or a mishandled simultaneous push and pop shows up as a wrong level or a wrong payload on the link.

// File: rtl/slr_pkg.sv
package slr_pkg;
  localparam int NUM_SL = 4;
  localparam int SL_W   = $clog2(NUM_SL);
  typedef logic [SL_W-1:0] sl_t;
endpackage

// File: rtl/slr_fifo.sv
module slr_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              head_i,
  input  logic              tail_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic              ready_o,
  output logic              valid_o,
  output logic              head_o,
  output logic              tail_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int ENT_W = DATA_W + 2;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ENT_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic wr_en, rd_en;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign ready_o = (cnt_q != CNT_W'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign wr_en   = push_i && ready_o;
  assign rd_en   = pop_i && valid_o;
  assign {head_o, tail_o, data_o} = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_q] <= {head_i, tail_i, data_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) wr_q <= nxt(wr_q);
      if (rd_en) rd_q <= nxt(rd_q);
      case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> valid_o);
  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  p_full_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !rd_en) |=> !ready_o);
endmodule

// File: rtl/slr_credit.sv
module slr_credit #(
  parameter int DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic send_i,
  input  logic ret_i,
  output logic avail_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q;

  assign avail_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(DEPTH);
    end else begin
      case ({send_i, ret_i})
        2'b10:   cnt_q <= cnt_q - CW'(1);
        2'b01:   cnt_q <= cnt_q + CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_send_needs_credit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_i |-> avail_o);
  p_credit_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_i && !ret_i) |=> cnt_q == $past(cnt_q) - CW'(1));
  p_credit_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_i && ret_i) |=> $stable(cnt_q));
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/slr_sched.sv
module slr_sched
  import slr_pkg::*;
(
  input  logic [NUM_SL-1:0] elig_i,
  output logic [NUM_SL-1:0] grant_o,
  output sl_t               sel_o,
  output logic              any_o
);
  always_comb begin
    grant_o = '0;
    sel_o   = '0;
    for (int i = NUM_SL - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
        sel_o = sl_t'(i);
      end
    end
  end

  assign any_o = |elig_i;

  always_comb begin
    a_one_grant_r7: assert ($onehot0(grant_o));
  end

  for (genvar g = 1; g < NUM_SL; g++) begin : g_prio
    always_comb begin
      if (grant_o[g]) a_prio_r2: assert (elig_i[g-1:0] == '0);
    end
  end
endmodule

// File: rtl/slr_port.sv
module slr_port
  import slr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BUF_DEPTH  = 4,
  parameter int CRED_DEPTH = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SL-1:0]        in_valid_i,
  input  logic [NUM_SL*DATA_W-1:0] in_data_i,
  input  logic [NUM_SL-1:0]        in_head_i,
  input  logic [NUM_SL-1:0]        in_tail_i,
  output logic [NUM_SL-1:0]        in_ready_o,
  input  logic [NUM_SL-1:0]        credit_i,
  output logic                     link_valid_o,
  output logic [DATA_W-1:0]        link_data_o,
  output logic [SL_W-1:0]          link_sl_o,
  output logic                     link_head_o,
  output logic                     link_tail_o
);
  logic [NUM_SL-1:0] q_valid, q_head, q_tail, cred_ok, elig, grant;
  logic [DATA_W-1:0] q_data [NUM_SL];
  sl_t               sel;
  logic              any;

  for (genvar g = 0; g < NUM_SL; g++) begin : g_sl
    slr_fifo #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (in_valid_i[g]),
      .head_i  (in_head_i[g]),
      .tail_i  (in_tail_i[g]),
      .data_i  (in_data_i[g*DATA_W +: DATA_W]),
      .pop_i   (grant[g]),
      .ready_o (in_ready_o[g]),
      .valid_o (q_valid[g]),
      .head_o  (q_head[g]),
      .tail_o  (q_tail[g]),
      .data_o  (q_data[g])
    );

    slr_credit #(.DEPTH(CRED_DEPTH)) u_cred (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .send_i  (grant[g]),
      .ret_i   (credit_i[g]),
      .avail_o (cred_ok[g])
    );

    assign elig[g] = q_valid[g] && cred_ok[g];
  end

  slr_sched u_sched (
    .elig_i  (elig),
    .grant_o (grant),
    .sel_o   (sel),
    .any_o   (any)
  );

  assign link_valid_o = any;
  assign link_sl_o    = sel;
  assign link_data_o  = any ? q_data[sel] : '0;
  assign link_head_o  = any && q_head[sel];
  assign link_tail_o  = any && q_tail[sel];

  p_idle_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(q_valid & cred_ok)) |-> !link_valid_o);
  p_tag_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_valid_o |-> grant[link_sl_o]);
  p_resume_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig[NUM_SL-1] && !(|elig[NUM_SL-2:0])) |-> (link_valid_o && link_sl_o == sl_t'(NUM_SL-1)));
endmodule

// File: tb/slr_port_tb_top.sv
`timescale 1ns/1ps
module slr_port_tb_top;
  localparam int DW = 32;
  localparam int BD = 4;
  localparam int CD = 4;
  localparam int NL = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NL-1:0]   in_valid = '0, in_head = '0, in_tail = '0, credit = '0;
  logic [NL*DW-1:0] in_data = '0;
  logic [NL-1:0]   in_ready;
  logic            link_valid, link_head, link_tail;
  logic [DW-1:0]   link_data;
  logic [1:0]      link_sl;

  always #2.5 clk = ~clk;

  slr_port #(.DATA_W(DW), .BUF_DEPTH(BD), .CRED_DEPTH(CD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_head_i(in_head), .in_tail_i(in_tail),
    .in_ready_o(in_ready), .credit_i(credit),
    .link_valid_o(link_valid), .link_data_o(link_data), .link_sl_o(link_sl),
    .link_head_o(link_head), .link_tail_o(link_tail)
  );

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R6";
  logic [DW+1:0] m_q [NL][BD];
  int m_cnt [NL], m_rd [NL], m_wr [NL], m_cred [NL], pkt_rem [NL], nsent [NL];
  bit trk_pre = 0, trk_ord = 0;
  int pre_st = 0;
  int ord [8];
  int n_ord = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic put(input int l, input int len);
    in_valid[l] = 1'b1;
    in_data[l*DW +: DW] = $urandom;
    if (pkt_rem[l] == 0) begin
      in_head[l] = 1'b1;
      pkt_rem[l] = len;
    end else in_head[l] = 1'b0;
    in_tail[l] = (pkt_rem[l] == 1);
    pkt_rem[l]--;
  endtask

  task automatic auto_credit();
    for (int l = 0; l < NL; l++) credit[l] = (m_cred[l] < CD);
  endtask

  // compare current outputs with the model, then advance the model over the next edge
  task automatic cycle();
    int win = -1;
    logic [DW+1:0] ent;
    bit full_pre [NL];
    for (int l = 0; l < NL; l++) if (win < 0 && m_cnt[l] > 0 && m_cred[l] > 0) win = l;
    chk(link_valid == (win >= 0), "R7", "link_valid", link_valid, win >= 0);
    if (win >= 0 && link_valid) begin
      ent = m_q[win][m_rd[win]];
      chk(link_sl == 2'(win), cur_tag, "link_sl", link_sl, win);
      chk(link_data == ent[DW-1:0], cur_tag, "link_data", link_data, ent[DW-1:0]);
      chk({link_head, link_tail} == ent[DW+1:DW], "R8", "head/tail", {link_head, link_tail}, ent[DW+1:DW]);
      nsent[win]++;
      if (trk_pre) begin
        if (pre_st == 0 && win == 3) pre_st = 1;
        else if (pre_st == 1 && win == 0) pre_st = 2;
        else if (pre_st == 2 && win == 3) pre_st = 3;
      end
      if (trk_ord && n_ord < 8) begin ord[n_ord] = win; n_ord++; end
    end
    for (int l = 0; l < NL; l++) begin
      chk(in_ready[l] == (m_cnt[l] < BD), "R9", "in_ready", in_ready[l], m_cnt[l] < BD);
      full_pre[l] = (m_cnt[l] >= BD);
    end
    if (win >= 0) begin
      m_rd[win] = (m_rd[win] + 1) % BD;
      m_cnt[win]--;
      m_cred[win]--;
    end
    for (int l = 0; l < NL; l++) begin
      if (credit[l]) m_cred[l]++;
      if (in_valid[l] && !full_pre[l]) begin
        m_q[l][m_wr[l]] = {in_head[l], in_tail[l], in_data[l*DW +: DW]};
        m_wr[l] = (m_wr[l] + 1) % BD;
        m_cnt[l]++;
      end
    end
    @(negedge clk);
    in_valid = '0; in_head = '0; in_tail = '0; credit = '0;
  endtask

  initial begin
    #(100000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int l = 0; l < NL; l++) begin
      m_cnt[l] = 0; m_rd[l] = 0; m_wr[l] = 0; m_cred[l] = CD; pkt_rem[l] = 0; nsent[l] = 0;
    end
    // R1: idle while and after reset
    repeat (3) begin
      @(negedge clk);
      chk(link_valid == 1'b0, "R1", "link_valid in reset", link_valid, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 4'hf, "R1", "in_ready after reset", in_ready, 4'hf);
    chk(link_valid == 1'b0, "R1", "link idle after reset", link_valid, 0);

    // R4/R5: credit limit on one level
    cur_tag = "R4";
    for (int k = 0; k < 6; k++) begin put(1, 6); cycle(); end
    repeat (4) cycle();
    chk(nsent[1] == CD, "R1", "flits sent on reset credits", nsent[1], CD);
    while (m_cnt[1] < BD) begin put(1, 6); cycle(); end
    repeat (2) cycle();
    chk(nsent[1] == CD, "R4", "no send without credit", nsent[1], CD);
    credit[1] = 1'b1; cycle();
    repeat (3) cycle();
    chk(nsent[1] == CD + 1, "R5", "one flit per returned credit", nsent[1], CD + 1);
    cur_tag = "R5";
    repeat (20) begin auto_credit(); cycle(); end

    // R3: preemption inside a level-3 packet
    cur_tag = "R3";
    trk_pre = 1;
    for (int k = 0; k < 8; k++) begin
      if (k < 6) put(3, 6);
      if (k == 2 || k == 3) put(0, 2);
      auto_credit();
      cycle();
    end
    repeat (10) begin auto_credit(); cycle(); end
    trk_pre = 0;
    chk(pre_st == 3, "R3", "level 3 interrupted then resumed", pre_st, 3);

    // R2: all levels eligible in the same cycle
    cur_tag = "R2";
    trk_ord = 1;
    for (int l = 0; l < NL; l++) put(l, 1);
    auto_credit(); cycle();
    repeat (6) begin auto_credit(); cycle(); end
    trk_ord = 0;
    chk(n_ord == 4, "R2", "flit count", n_ord, 4);
    for (int i = 0; i < 4; i++) chk(ord[i] == i, "R2", "priority order", ord[i], i);

    // R6/R5: random traffic with colliding credit returns and pushes
    cur_tag = "R6";
    for (int c = 0; c < 4000; c++) begin
      for (int l = 0; l < NL; l++) begin
        if (m_cnt[l] < BD && $urandom_range(0, 99) < 20 + 15 * l) put(l, $urandom_range(1, 5));
        if (m_cred[l] < CD && $urandom_range(0, 99) < 55) credit[l] = 1'b1;
      end
      cycle();
    end
    repeat (40) begin auto_credit(); cycle(); end
    chk(link_valid == 1'b0, "R7", "idle after drain", link_valid, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule